// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a receive-only two-wire bus slave that lets a host load one 8-bit control word into a headphone amplifier's digital section. Both bus lines are oversampled by a fast system clock. Each line passes through a synchroniser and a glitch filter. Bus conditions are then derived from the filtered levels. The slave answers one of two 7-bit addresses, chosen by a static strap input. It pulls the data line low only during acknowledge clocks. It never returns data.

A received command byte is held in a staging register and is copied into the live control register only when the frame closes with a STOP. A repeated START, or a STOP in the middle of a byte, drops the staged byte. The live register drives four outputs:

- an amplifier enable, which is also gated by an active-low hardware shutdown pin;
- a bass-boost enable;
- a maximum-gain select;
- a 5-bit volume code.

The receiver is a six-state machine. Its states and transitions are as follows.

- IDLE waits for a START.
- ADDR shifts in the address byte on SCL rising edges. It goes to ADDR_ACK on the SCL fall after the eighth bit if the address matches, and to SKIP if it does not.
- ADDR_ACK drives the acknowledge. On the next SCL fall it goes to DATA for a write, or to SKIP for a read.
- DATA shifts in the command byte. On the SCL fall after the eighth bit it goes to DATA_ACK.
- DATA_ACK drives the acknowledge, then goes to SKIP on the next SCL fall.
- SKIP ignores the bus until the next START or STOP.

A START from any state leads to ADDR. A valid STOP from any state leads to IDLE.

Top module: `cfgi2c_slave`

## Requirements
- R1: After reset the control register holds 0xFF. With the shutdown pin high, this gives amplifier enabled, bass on, high gain select and volume 31.
- R2: The address is received as 7 bits, MSB first, followed by the R/W bit. The upper six bits must be 100110, and the lowest bit must equal `addr_sel_i`. A matching address is acknowledged by asserting `sda_oe_o` across the ninth SCL high phase.
- R3: A non-matching address is not acknowledged. Neither is any later byte of that frame, and the frame leaves the register unchanged.
- R4: In a frame made of START, matching address with R/W = 0, one byte and STOP, the byte is acknowledged. The outputs keep their old value until the STOP, and take the new byte after it.
- R5: A second data byte in the same frame is not acknowledged and is discarded. The first byte is the one committed on STOP.
- R6: A matching address with R/W = 1 is acknowledged. After that, `sda_oe_o` stays low for the rest of the frame, and the register is unchanged.
- R7: A repeated START discards any staged byte and restarts address reception. A START releases `sda_oe_o` by the following cycle.
- R8: A STOP that falls in the same SCL high pulse as a START is ignored, and address reception continues.
- R9: A STOP in the middle of the address or the data byte ends the frame without changing the register.
- R10: Register bit 7 enables the amplifier, bit 6 the bass boost, and bit 5 is the gain select. Bits 4:0 are the volume code, where 00000 means mute.
- R11: `amp_en_o` is high only when `shdn_n_i` is high and bit 7 is 1. Writes are accepted and stored while in shutdown.
- R12: `sda_oe_o` changes only while the filtered SCL is low.
- R13: A pulse on SCL shorter than the filter length (3 system clocks) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| addr_sel_i | input | 1 | Static strap that sets the address LSB |
| shdn_n_i | input | 1 | Hardware shutdown pin, active low |
| amp_en_o | output | 1 | Amplifier enable |
| bass_en_o | output | 1 | Bass-boost enable |
| gain_hi_o | output | 1 | Maximum-gain select |
| vol_o | output | 5 | Volume code, 0 = mute |

## Verification
Some properties are checked on every cycle: the shutdown pin forcing the enable low, the register holding its value except on a commit, the acknowledge driver switching only while SCL is low, and the release of the data line after a START. Other behaviours can only be shown by the bench's bus scenarios. These are address matching under both strap values, the ignored read and extra bytes, the staged byte dropped by a repeated START or an early STOP, the STOP that shares a SCL high pulse with a START, and SCL glitch rejection. Each of them depends on a whole sequence of bus edges, not on a relation between adjacent cycles.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int CMD_W    = 8;
    localparam int VOL_W    = 5;
    localparam int EN_BIT   = 7;
    localparam int BASS_BIT = 6;
    localparam int GAIN_BIT = 5;
    localparam logic [CMD_W-1:0] CMD_RESET = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } fsm_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

endpackage

// File: rtl/cfgi2c_line_filter.sv
module cfgi2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   raw;
    logic [CW-1:0]          cnt_q;
    logic                   level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    assign raw = sync_q[SYNC_STAGES-1];

    // the level moves only after FILT_LEN consecutive differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else if (raw == level_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            cnt_q   <= '0;
            level_q <= raw;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign line_o = level_q;
endmodule

// File: rtl/cfgi2c_bus_events.sv
module cfgi2c_bus_events import cfgi2c_pkg::*; (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q, start_seen_q;
    logic start_raw, stop_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q        <= 1'b1;
            sda_q        <= 1'b1;
            start_seen_q <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (start_raw)   start_seen_q <= 1'b1;
            else if (!scl_f) start_seen_q <= 1'b0;
        end
    end

    assign start_raw   = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_raw    = scl_f & scl_q & ~sda_q & sda_f;

    assign ev.start    = start_raw;
    assign ev.stop     = stop_raw & ~start_seen_q;
    assign ev.scl_rise = scl_f & ~scl_q;
    assign ev.scl_fall = ~scl_f & scl_q;
endmodule

// File: rtl/cfgi2c_ctrl_fsm.sv
module cfgi2c_ctrl_fsm import cfgi2c_pkg::*; #(
    parameter logic [5:0] DEV_ADDR_HI = 6'b100110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_ev_t          ev,
    input  logic             sda_f,
    input  logic             addr_sel_i,
    output logic             sda_oe,
    output logic             commit,
    output logic [CMD_W-1:0] pend_byte
);
    localparam int BCW = $clog2(CMD_W + 1);

    fsm_state_t       state_q, state_d;
    logic [BCW-1:0]   bit_cnt_q;
    logic [CMD_W-1:0] shift_q;
    logic [CMD_W-1:0] pend_q;
    logic             pend_vld_q;
    logic             rw_q;
    logic             byte_done;
    logic             addr_hit;
    logic             shifting;

    assign byte_done = (bit_cnt_q == BCW'(CMD_W));
    assign addr_hit  = (shift_q[7:1] == {DEV_ADDR_HI, addr_sel_i});
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_DATA);

    always_comb begin
        state_d = state_q;
        if (ev.start) begin
            state_d = ST_ADDR;
        end else if (ev.stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (ev.scl_fall && byte_done)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (ev.scl_fall)
                                 state_d = rw_q ? ST_SKIP : ST_DATA;
                ST_DATA:     if (ev.scl_fall && byte_done)
                                 state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (ev.scl_fall)
                                 state_d = ST_SKIP;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            rw_q       <= 1'b0;
        end else if (ev.start || ev.stop) begin
            bit_cnt_q  <= '0;
            pend_vld_q <= 1'b0;
        end else begin
            if (ev.scl_rise && shifting && !byte_done) begin
                shift_q   <= {shift_q[CMD_W-2:0], sda_f};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (ev.scl_fall && state_q == ST_ADDR && byte_done)
                rw_q <= shift_q[0];
            if (ev.scl_fall && state_q == ST_ADDR_ACK)
                bit_cnt_q <= '0;
            if (ev.scl_fall && state_q == ST_DATA && byte_done) begin
                pend_q     <= shift_q;
                pend_vld_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            default:                  sda_oe = 1'b0;
        endcase
        commit    = ev.stop & pend_vld_q;
        pend_byte = pend_q;
    end
endmodule

// File: rtl/cfgi2c_slave.sv
module cfgi2c_slave import cfgi2c_pkg::*; #(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [5:0] DEV_ADDR_HI = 6'b100110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             addr_sel_i,
    input  logic             shdn_n_i,
    output logic             amp_en_o,
    output logic             bass_en_o,
    output logic             gain_hi_o,
    output logic [VOL_W-1:0] vol_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] lines_raw;
    logic [NLINES-1:0] lines_filt;
    bus_ev_t           bus_ev;
    logic              commit_w;
    logic [CMD_W-1:0]  pend_w;
    logic [CMD_W-1:0]  cmd_q;

    // index 0 is the clock line, index 1 the data line
    assign lines_raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        cfgi2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(lines_raw[g]),
            .line_o(lines_filt[g])
        );
    end

    cfgi2c_bus_events u_events (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(lines_filt[0]),
        .sda_f(lines_filt[1]),
        .ev   (bus_ev)
    );

    cfgi2c_ctrl_fsm #(
        .DEV_ADDR_HI(DEV_ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (bus_ev),
        .sda_f     (lines_filt[1]),
        .addr_sel_i(addr_sel_i),
        .sda_oe    (sda_oe_o),
        .commit    (commit_w),
        .pend_byte (pend_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cmd_q <= CMD_RESET;
        else if (commit_w) cmd_q <= pend_w;
    end

    assign amp_en_o  = shdn_n_i & cmd_q[EN_BIT];
    assign bass_en_o = cmd_q[BASS_BIT];
    assign gain_hi_o = cmd_q[GAIN_BIT];
    assign vol_o     = cmd_q[VOL_W-1:0];
endmodule

// File: rtl/cfgi2c_slave_chk.sv
module cfgi2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       shdn_n,
    input logic       amp_en,
    input logic       commit,
    input logic       start_ev,
    input logic [7:0] cmd_q
);
    // R11
    shdn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> !amp_en);

    // R4
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cmd_q));

    // R12
    ack_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R12
    ack_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f);

    // R7
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);
endmodule

bind cfgi2c_slave cfgi2c_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (lines_filt[0]),
    .sda_oe  (sda_oe_o),
    .shdn_n  (shdn_n_i),
    .amp_en  (amp_en_o),
    .commit  (commit_w),
    .start_ev(bus_ev.start),
    .cmd_q   (cmd_q)
);

// File: tb/cfgi2c_slave_bench.sv
module cfgi2c_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       sda_oe_o, addr_sel_i, shdn_n_i;
    logic       amp_en_o, bass_en_o, gain_hi_o;
    logic [4:0] vol_o;
    logic       sda_line;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;

    // open-drain bus: either side may pull the data line low
    assign sda_line = sda_m & ~sda_oe_o;

    cfgi2c_slave u_cfgi2c_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe_o),
        .addr_sel_i(addr_sel_i),
        .shdn_n_i  (shdn_n_i),
        .amp_en_o  (amp_en_o),
        .bass_en_o (bass_en_o),
        .gain_hi_o (gain_hi_o),
        .vol_o     (vol_o)
    );

    // {addr[6:0], data[7:0], expect_ack, expected register}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {7'h4C, 8'h8A, 1'b1, 8'h8A},
        {7'h4D, 8'h55, 1'b0, 8'h8A},
        {7'h4C, 8'h00, 1'b1, 8'h00},
        {7'h19, 8'hFF, 1'b0, 8'h00},
        {7'h4C, 8'hE3, 1'b1, 8'hE3},
        {7'h4C, 8'h7F, 1'b1, 8'h7F}
    };

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {amp_en_o, bass_en_o, gain_hi_o, vol_o};
    endfunction

    task automatic bus_start();
        sda_m = 1'b0; wait_clks(24); scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_clks(14); sda_m = 1'b1; wait_clks(14); scl_m = 1'b1;
        wait_clks(24); sda_m = 1'b0; wait_clks(24); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clks(14); sda_m = 1'b0; wait_clks(14); scl_m = 1'b1;
        wait_clks(24); sda_m = 1'b1; wait_clks(48);
    endtask

    task automatic send_bit(input logic b, input logic glitch, output logic oe_hi);
        wait_clks(14); sda_m = b;
        if (glitch) begin
            wait_clks(5); scl_m = 1'b1; wait_clks(1); scl_m = 1'b0; wait_clks(8);
        end else begin
            wait_clks(14);
        end
        scl_m = 1'b1; wait_clks(12); oe_hi = sda_oe_o; wait_clks(12); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input int glitch_at,
                             output logic acked, output logic drove);
        logic s;
        drove = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            send_bit(d[i], i == glitch_at, s);
            drove |= s;
        end
        send_bit(1'b1, 1'b0, acked);
    endtask

    task automatic write_frame(input logic [6:0] a, input logic [7:0] d,
                               output logic ack_a, output logic ack_d);
        logic dr;
        bus_start();
        send_byte({a, 1'b0}, -1, ack_a, dr);
        send_byte(d, -1, ack_d, dr);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic aa, ad, dr;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        addr_sel_i = 1'b0; shdn_n_i = 1'b1;
        wait_clks(5); rst_n = 1'b1; wait_clks(5);

        // R1 reset state
        chk("R1 reset value", outs(), 8'hFF);
        chk("R12 idle release", sda_oe_o, 1'b0);

        // vector walk: R2 R3 R4 R5 R10
        for (int i = 0; i < NVEC; i++) begin
            write_frame(VEC[i][23:17], VEC[i][16:9], aa, ad);
            chk("R2/R3 addr ack", aa, VEC[i][8]);
            chk("R3/R4 data ack", ad, VEC[i][8]);
            chk("R10 register fields", outs(), VEC[i][7:0]);
        end

        // R10 bit 7 cleared disables the amplifier, R11 shutdown pin
        chk("R10 enable bit", amp_en_o, 1'b0);
        shdn_n_i = 1'b0;
        write_frame(7'h4C, 8'h9F, aa, ad);
        chk("R11 write in shutdown ack", ad, 1'b1);
        chk("R11 shutdown gate", amp_en_o, 1'b0);
        chk("R11 stored fields", {bass_en_o, gain_hi_o, vol_o}, 7'h1F);
        shdn_n_i = 1'b1; wait_clks(2);
        chk("R11 wake", amp_en_o, 1'b1);

        // R2 strap selects the address LSB
        addr_sel_i = 1'b1; wait_clks(4);
        write_frame(7'h4D, 8'hA1, aa, ad);
        chk("R2 strap high match", aa, 1'b1);
        chk("R2 strap high value", outs(), 8'hA1);
        write_frame(7'h4C, 8'h33, aa, ad);
        chk("R3 strap high mismatch", aa, 1'b0);
        chk("R3 register kept", outs(), 8'hA1);
        addr_sel_i = 1'b0; wait_clks(4);

        // R4 commit only at STOP
        bus_start();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        send_byte(8'h3C, -1, ad, dr);
        wait_clks(10);
        chk("R4 held before stop", outs(), 8'hA1);
        bus_stop();
        chk("R4 committed at stop", outs(), 8'hBC & 8'h3C | 8'h00);

        // R5 second byte ignored
        bus_start();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        send_byte(8'h44, -1, ad, dr);
        chk("R5 first byte ack", ad, 1'b1);
        send_byte(8'h99, -1, ad, dr);
        chk("R5 second byte nack", ad, 1'b0);
        bus_stop();
        chk("R5 first byte kept", outs(), 8'h44);

        // R6 read address: ack then never drive
        bus_start();
        send_byte({7'h4C, 1'b1}, -1, aa, dr);
        chk("R6 read ack", aa, 1'b1);
        send_byte(8'hFF, -1, ad, dr);
        chk("R6 no drive in data", dr, 1'b0);
        chk("R6 no drive at ninth clock", ad, 1'b0);
        bus_stop();
        chk("R6 register kept", outs(), 8'h44);

        // R7 repeated START discards staged byte
        bus_start();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        send_byte(8'h11, -1, ad, dr);
        bus_rstart();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        chk("R7 readdress ack", aa, 1'b1);
        send_byte(8'h22, -1, ad, dr);
        bus_stop();
        chk("R7 second write wins", outs(), 8'h22);
        bus_start();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        send_byte(8'h66, -1, ad, dr);
        bus_rstart();
        send_byte({7'h4C, 1'b1}, -1, aa, dr);
        send_byte(8'hFF, -1, ad, dr);
        bus_stop();
        chk("R7 staged byte discarded", outs(), 8'h22);

        // R8 STOP in same high pulse as START ignored
        sda_m = 1'b0; wait_clks(12); sda_m = 1'b1; wait_clks(12); scl_m = 1'b0;
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        chk("R8 address still received", aa, 1'b1);
        send_byte(8'h5A, -1, ad, dr);
        bus_stop();
        chk("R8 frame committed", outs(), 8'h5A);

        // R9 early STOP in data and in address
        bus_start();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0, dr);
        bus_stop();
        chk("R9 early stop in data", outs(), 8'h5A);
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, dr);
        bus_stop();
        write_frame(7'h4C, 8'hC7, aa, ad);
        chk("R9 recovery after early stop", outs(), 8'hC7);

        // R13 glitch on SCL ignored
        bus_start();
        send_byte({7'h4C, 1'b0}, -1, aa, dr);
        send_byte(8'h96, 3, ad, dr);
        chk("R13 glitch byte ack", ad, 1'b1);
        bus_stop();
        chk("R13 glitch rejected", outs(), 8'h96);

        // R1 reset mid-run
        rst_n = 1'b0; wait_clks(4); rst_n = 1'b1; wait_clks(4);
        chk("R1 reset restores", outs(), 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule